// File: doc/BRIEF.md
# Dual-Lane Serial Result Shifter

This block reads a bank of eight 16-bit conversion results out over two serial data lines. The host frames a read by pulling the active-low chip select low and supplies the serial clock. The block shifts channels 1 to 4 out on lane A and channels 5 to 8 out on lane B at the same time, so a host that listens to both lanes reads the whole bank in 64 clocks. A host wired to lane A only keeps clocking: after the first 64 bits, lane A carries on with channels 5 to 8, and all eight results arrive in 128 clocks.

The result bank is captured into a holding register when the converter's busy flag falls. A read taken while busy is high therefore returns the previous conversion's results. The word set for a frame is copied from the holding register when chip select falls, so a capture during a frame does not disturb it. Chip select, serial clock and busy are sampled into the block's own clock domain through two-stage synchronisers. While chip select is high, the line drivers are disabled and both lines read 0.

Top module: `dualLaneShifter`

## Requirements
- R1: While chip select is high, `doutEn` is 0, `doutA` and `doutB` are 0, and serial clock edges do not move the bit position.
- R2: When chip select falls, before any serial clock, lane A presents the MSB of channel 1 and lane B presents the MSB of channel 5.
- R3: Each serial clock falling edge inside a frame advances both lanes by one bit. The serial clock idles low and the host samples on rising edges. Each half period lasts at least 4 `clk` cycles.
- R4: With both lanes in use, the first 64 bits are channels 1, 2, 3 and 4 on lane A and channels 5, 6, 7 and 8 on lane B. Each channel is 16 bits, sent MSB first.
- R5: With lane A alone, bits 64 to 127 of lane A are channels 5 to 8, MSB first. Lane B drives 0 from bit 64 on.
- R6: The result bank is captured on a falling edge of `busy`. A read started while `busy` is high returns the previously captured results. After `busy` falls, the next frame returns the new results.
- R7: A capture that happens during a frame does not change the bits of that frame.
- R8: After 128 bits, both lanes drive 0 and further serial clocks do not move the bit position.
- R9: Raising chip select in the middle of a frame and lowering it again restarts the readout at the MSB of channel 1 and channel 5.
- R10: Channel k (1 to 8) occupies bits [16k-1 : 16k-16] of `resultBank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the host signals |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| busy | input | 1 | Converter busy flag; its falling edge captures the bank |
| resultBank | input | 128 | Eight 16-bit results, channel 1 in the lowest bits |
| doutA | output | 1 | Serial data lane A |
| doutB | output | 1 | Serial data lane B |
| doutEn | output | 1 | Line driver enable; 0 means both lanes are released |

## Verification
The bench gives every channel a distinct value, so a swapped channel, a swapped lane or a reversed bit order each shows up as a mismatch on a named channel. Frames of three lengths are used, and each one tells a different fault apart. A 64-clock frame checks the split across the two lanes. A 128-clock frame checks that lane A continues into channels 5 to 8. A 136-clock frame checks that the bit position stops at 128. Busy is held high across a frame, and a busy pulse is placed in the middle of another frame; these separate the capture on busy's falling edge from the frame copy taken when chip select falls. A short frame followed by a full one shows that a new chip select restarts the readout from the first bit.

// File: rtl/shifterPkg.sv
package shifterPkg;
  typedef struct packed {
    logic capture;    // busy fell: refresh holding register
    logic loadFrame;  // chip select fell: copy holding register into frame
    logic advance;    // serial clock fell inside a frame
    logic active;     // frame open, lines driven
  } ctrlStrobesT;
endpackage

// File: rtl/shifterCtrl.sv
module shifterCtrl
  import shifterPkg::*;
#(
  parameter int TOTAL_BITS = 128,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             busy,
  output ctrlStrobesT      strb,
  output logic [CNT_W-1:0] bitIdx
);
  logic [1:0] csPipe, sclkPipe, busyPipe;
  logic       csPrev, sclkPrev, busyPrev;
  logic       csLow, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= 2'b11;
      sclkPipe <= 2'b00;
      busyPipe <= 2'b00;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      busyPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[0], csN};
      sclkPipe <= {sclkPipe[0], sclk};
      busyPipe <= {busyPipe[0], busy};
      csPrev   <= csPipe[1];
      sclkPrev <= sclkPipe[1];
      busyPrev <= busyPipe[1];
    end
  end

  assign csLow    = ~csPipe[1];
  assign sclkFall = sclkPrev & ~sclkPipe[1];

  always_comb begin
    strb.active    = csLow;
    strb.loadFrame = csPrev & csLow;
    strb.capture   = busyPrev & ~busyPipe[1];
    strb.advance   = csLow & ~(csPrev & csLow) & sclkFall
                     & (bitIdx < CNT_W'(TOTAL_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitIdx <= '0;
    else if (strb.loadFrame) bitIdx <= '0;
    else if (strb.advance)   bitIdx <= bitIdx + 1'b1;
  end
endmodule

// File: rtl/shifterDatapath.sv
module shifterDatapath
  import shifterPkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int WIDTH    = 16,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobesT               strb,
  input  logic [CNT_W-1:0]          bitIdx,
  input  logic [CHANNELS*WIDTH-1:0] resultBank,
  output logic                      doutA,
  output logic                      doutB,
  output logic                      doutEn
);
  localparam int BANK_W     = CHANNELS * WIDTH;
  localparam int TOTAL_BITS = BANK_W;
  localparam int HALF_BITS  = BANK_W / 2;
  localparam int LANES      = 2;

  logic [BANK_W-1:0] holdReg, frameReg;
  logic [LANES-1:0]  laneBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      frameReg <= '0;
    end else begin
      if (strb.capture)   holdReg  <= resultBank;
      if (strb.loadFrame) frameReg <= holdReg;
    end
  end

  // Stream position n maps to channel n/WIDTH, bit WIDTH-1-(n%WIDTH).
  function automatic logic pickBit(input logic [BANK_W-1:0] v, input int unsigned n);
    int unsigned ch;
    int unsigned b;
    logic [BANK_W-1:0] sh;
    ch = n / WIDTH;
    b  = WIDTH - 1 - (n % WIDTH);
    sh = v >> (ch * WIDTH + b);
    return sh[0];
  endfunction

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam int OFFSET = L * HALF_BITS;
    localparam int LIMIT  = (L == 0) ? TOTAL_BITS : HALF_BITS;
    always_comb begin
      if (strb.active && (int'(bitIdx) < LIMIT))
        laneBit[L] = pickBit(frameReg, int'(bitIdx) + OFFSET);
      else
        laneBit[L] = 1'b0;
    end
  end

  assign doutA  = laneBit[0];
  assign doutB  = laneBit[1];
  assign doutEn = strb.active;
endmodule

// File: rtl/dualLaneShifter.sv
module dualLaneShifter
  import shifterPkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int WIDTH    = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      busy,
  input  logic [CHANNELS*WIDTH-1:0] resultBank,
  output logic                      doutA,
  output logic                      doutB,
  output logic                      doutEn
);
  localparam int TOTAL_BITS = CHANNELS * WIDTH;
  localparam int HALF_BITS  = TOTAL_BITS / 2;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);

  ctrlStrobesT      strb;
  logic [CNT_W-1:0] bitIdx;

  shifterCtrl #(.TOTAL_BITS(TOTAL_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
    .strb(strb), .bitIdx(bitIdx)
  );

  shifterDatapath #(.CHANNELS(CHANNELS), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .resultBank(resultBank), .doutA(doutA), .doutB(doutB), .doutEn(doutEn)
  );
endmodule

// File: rtl/shifterChecker.sv
module shifterChecker
  import shifterPkg::*;
#(
  parameter int TOTAL_BITS = 128,
  parameter int HALF_BITS  = 64,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStrobesT      strb,
  input logic [CNT_W-1:0] bitIdx,
  input logic             doutB,
  input logic             doutEn
);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> (bitIdx == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (bitIdx == $past(bitIdx) + 1'b1));

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= CNT_W'(TOTAL_BITS));

  p_laneb_tail_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && (bitIdx >= CNT_W'(HALF_BITS))) |-> !doutB);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !doutEn |=> $stable(bitIdx));
endmodule

bind dualLaneShifter shifterChecker #(
  .TOTAL_BITS(TOTAL_BITS), .HALF_BITS(HALF_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
  .doutB(doutB), .doutEn(doutEn)
);

// File: tb/sim_dualLaneShifter.sv
module sim_dualLaneShifter;
  logic clk = 0, rstN = 0, csN = 1, sclk = 0, busy = 0;
  logic [127:0] resultBank = '0;
  logic doutA, doutB, doutEn;
  int nChecks = 0, nFails = 0;
  logic sA[0:159];
  logic sB[0:159];
  logic [127:0] bankP1, bankP2, bankP3;

  always #5 clk = ~clk;

  dualLaneShifter u0 (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
    .resultBank(resultBank), .doutA(doutA), .doutB(doutB), .doutEn(doutEn));

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] chan(input logic [127:0] b, input int k);
    return b[(k-1)*16 +: 16];  // R10: channel k placement
  endfunction

  function automatic logic [15:0] wordA(input int startBit);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = sA[startBit+i];
    return w;
  endfunction

  function automatic logic [15:0] wordB(input int startBit);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = sB[startBit+i];
    return w;
  endfunction

  task automatic capture(input logic [127:0] v);
    resultBank = v;
    busy = 1;
    repeat (4) @(posedge clk);
    busy = 0;
    repeat (6) @(posedge clk);
  endtask

  // Opens a frame and samples n bits; optional busy pulse with newBank at bit capAt.
  task automatic readFrame(input int n, input int capAt, input logic [127:0] newBank);
    csN = 0;
    repeat (8) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sA[i] = doutA;
      sB[i] = doutB;
      if (i == capAt) begin resultBank = newBank; busy = 1; end
      if (i == capAt + 2) busy = 0;
      sclk = 1;
      repeat (6) @(posedge clk);
      sclk = 0;
      repeat (6) @(posedge clk);
    end
    repeat (2) @(posedge clk);
  endtask

  task automatic endFrame();
    csN = 1;
    repeat (6) @(posedge clk);
  endtask

  task automatic tReset();
    @(negedge clk);
    check(doutEn == 0, "R1 reset enable", {15'b0, doutEn}, 16'h0);
    check({doutA, doutB} == 2'b00, "R1 reset lines", {14'b0, doutA, doutB}, 16'h0);
  endtask

  task automatic tDual();
    capture(bankP1);
    readFrame(64, -1, '0);
    check(sA[0] == bankP1[15] && sB[0] == bankP1[79], "R2 first bits",
          {14'b0, sA[0], sB[0]}, {14'b0, bankP1[15], bankP1[79]});
    for (int k = 1; k <= 4; k++) begin
      check(wordA((k-1)*16) == chan(bankP1, k), "R4 lane A channel", wordA((k-1)*16), chan(bankP1, k));
      check(wordB((k-1)*16) == chan(bankP1, k+4), "R4 lane B channel", wordB((k-1)*16), chan(bankP1, k+4));
    end
    endFrame();
    @(negedge clk);
    check(!doutEn && !doutA && !doutB, "R1 idle after frame", {13'b0, doutEn, doutA, doutB}, 16'h0);
  endtask

  task automatic tSingle();
    readFrame(128, -1, '0);
    for (int k = 1; k <= 8; k++)
      check(wordA((k-1)*16) == chan(bankP1, k), "R5 single lane channel", wordA((k-1)*16), chan(bankP1, k));
    for (int k = 5; k <= 8; k++)
      check(wordB((k-1)*16) == 16'h0, "R5 lane B tail", wordB((k-1)*16), 16'h0);
    endFrame();
  endtask

  task automatic tOverrun();
    readFrame(136, -1, '0);
    check(wordA(112) == chan(bankP1, 8), "R8 last channel", wordA(112), chan(bankP1, 8));
    begin
      logic [7:0] tailA, tailB;
      for (int i = 0; i < 8; i++) begin tailA[i] = sA[128+i]; tailB[i] = sB[128+i]; end
      check(tailA == 8'h0 && tailB == 8'h0, "R8 beyond end", {tailA, tailB}, 16'h0);
    end
    endFrame();
  endtask

  task automatic tBusy();
    resultBank = bankP2;
    busy = 1;
    repeat (4) @(posedge clk);
    readFrame(64, -1, '0);
    check(wordA(0) == chan(bankP1, 1), "R6 busy high gives previous", wordA(0), chan(bankP1, 1));
    check(wordB(48) == chan(bankP1, 8), "R6 busy high gives previous B", wordB(48), chan(bankP1, 8));
    endFrame();
    busy = 0;
    repeat (6) @(posedge clk);
    readFrame(64, -1, '0);
    check(wordA(16) == chan(bankP2, 2), "R6 new data after busy falls", wordA(16), chan(bankP2, 2));
    check(wordB(32) == chan(bankP2, 7), "R6 new data lane B", wordB(32), chan(bankP2, 7));
    endFrame();
  endtask

  task automatic tMidCapture();
    readFrame(64, 20, bankP3);
    for (int k = 1; k <= 4; k++)
      check(wordA((k-1)*16) == chan(bankP2, k), "R7 frame unchanged", wordA((k-1)*16), chan(bankP2, k));
    check(wordB(48) == chan(bankP2, 8), "R7 frame unchanged B", wordB(48), chan(bankP2, 8));
    endFrame();
  endtask

  task automatic tRestart();
    readFrame(10, -1, '0);
    csN = 1;
    repeat (4) @(posedge clk);
    // serial clocks with chip select high must not move the position (R1)
    for (int i = 0; i < 3; i++) begin
      sclk = 1; repeat (6) @(posedge clk); sclk = 0; repeat (6) @(posedge clk);
    end
    readFrame(64, -1, '0);
    check(wordA(0) == chan(bankP3, 1), "R9 restart lane A", wordA(0), chan(bankP3, 1));
    check(wordB(0) == chan(bankP3, 5), "R9 restart lane B", wordB(0), chan(bankP3, 5));
    check(wordA(48) == chan(bankP3, 4), "R3 bit stepping", wordA(48), chan(bankP3, 4));
    endFrame();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      bankP1[k*16 +: 16] = 16'h8000 | 16'(k * 16'h1111 + 16'h0123);
      bankP2[k*16 +: 16] = 16'(16'hC35A ^ (k * 16'h0F0F));
      bankP3[k*16 +: 16] = 16'(16'h0001 << (2 * k)) | 16'h4000;
    end
    repeat (3) @(posedge clk);
    rstN = 1;
    repeat (3) @(posedge clk);
    tReset();
    tDual();
    tSingle();
    tOverrun();
    tBusy();
    tMidCapture();
    tRestart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule